// File: doc/BRIEF.md
# USB Device Interrupt Flag Controller

This block turns single-cycle event strobes from a USB device protocol engine into sticky interrupt flags. Each endpoint has seven flags: IN transfer done, OUT data received into bank 0 or bank 1, SETUP received, NAK seen on IN, NAK seen on OUT, and STALL sent. Three device-wide flags record start-of-frame, bus suspend and wake-up after a suspend.

Every flag has its own enable bit. The OR of all enabled flags is registered into a pending bit. The pending bit reaches the CPU-side interrupt controller only while both the global interrupt enable and the USB interrupt enable are set. A 2-bit priority level travels with the request.

Software uses a small register bus. It reads flags, clears them by writing ones, and sets the enables, the two gates and the two priority bits.

Top module: `usb_irq_flags`

## Requirements
- R1: A `ev_tx_done[e]` pulse sets bit 0 of endpoint e's flag register (address e) on the next clock edge.
- R2: `ev_rx_bank0[e]` sets bit 1 and `ev_rx_bank1[e]` sets bit 2 of endpoint e's flag register. Endpoint 0 is a control endpoint: its bit 2 always reads 0, and a bank-1 event on endpoint 0 has no effect.
- R3: A `ev_setup[e]` pulse sets bit 3 of endpoint e's flag register.
- R4: `ev_nak_in[e]` sets bit 4 and `ev_nak_out[e]` sets bit 5. These bits hold until software writes 1 to them. Writing 0 leaves them set.
- R5: `ev_stall_sent[e]` sets bit 6. A SETUP event on the same endpoint clears bit 6, including when both events arrive in the same cycle; bit 3 still ends up set.
- R6: The global flag register (address 2·NUM_EP) has three bits. Bit 0 is set by `ev_sof` and bit 1 by `ev_suspend`. Bit 2 is set by `ev_resume` only when a suspend has been seen with no resume since; a resume with no prior suspend leaves bit 2 clear.
- R7: All flag bits are write-one-to-clear. If a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set; other bits cleared by that write still clear.
- R8: Enable registers sit at addresses NUM_EP+e (endpoint e, bits 0..6) and 2·NUM_EP+1 (global, bits 0..2). The pending bit is the registered OR of all enabled flags. It rises one cycle after the flag sets. `irq` equals the pending bit gated by control bit 0 (global enable) and control bit 1 (USB enable); the control register is at address 2·NUM_EP+2.
- R9: `irq_prio` equals {control bit 3, control bit 2}. 0 is the lowest level and 3 the highest.
- R10: After reset, all flags, enables and control bits read 0, and `irq` and `irq_prio` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_tx_done | input | NUM_EP | IN packet accepted by host, per endpoint |
| ev_rx_bank0 | input | NUM_EP | OUT packet stored in bank 0 |
| ev_rx_bank1 | input | NUM_EP | OUT packet stored in bank 1 |
| ev_setup | input | NUM_EP | SETUP packet accepted |
| ev_nak_in | input | NUM_EP | NAK handshake on IN |
| ev_nak_out | input | NUM_EP | NAK handshake on OUT |
| ev_stall_sent | input | NUM_EP | STALL handshake sent |
| ev_sof | input | 1 | Start-of-frame received |
| ev_suspend | input | 1 | Bus suspend detected |
| ev_resume | input | 1 | Bus resume detected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| irq_prio | output | 2 | Request priority level |

## Verification
The hardest situations to reach are the collisions: a hardware set landing in the same cycle as a software clear, and a SETUP landing in the same cycle as a STALL-sent strobe. The bench drives the event strobe and the register write on the same falling edge, so both act on one rising edge. It then reads the flag register back. The wake-up qualification is reached by sending a resume both before and after a suspend.

// File: rtl/usbirq_pkg.sv
// Shared bit positions for the USB interrupt flag controller.
// Assumes 8-bit register data; flag fields never exceed that width.
package usbirq_pkg;
    localparam int EP_W    = 7;
    localparam int F_TX    = 0;
    localparam int F_RXB0  = 1;
    localparam int F_RXB1  = 2;
    localparam int F_SETUP = 3;
    localparam int F_NAKI  = 4;
    localparam int F_NAKO  = 5;
    localparam int F_STALL = 6;
    localparam int GL_W    = 3;
    localparam int G_SOF   = 0;
    localparam int G_SUSP  = 1;
    localparam int G_WAKE  = 2;
    localparam int C_GIE   = 0;
    localparam int C_USBIE = 1;
    localparam int C_PLO   = 2;
    localparam int C_PHI   = 3;
endpackage

// File: rtl/usbirq_ep_flags.sv
// Sticky flag set for one endpoint. Set beats software clear; SETUP
// clears the stall flag. HAS_BANK1=0 removes the bank-1 flag.
// Assumes event inputs are single-cycle strobes.
module usbirq_ep_flags
    import usbirq_pkg::*;
#(
    parameter bit HAS_BANK1 = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx,
    input  logic            rxb0,
    input  logic            rxb1,
    input  logic            setup,
    input  logic            nakin,
    input  logic            nakout,
    input  logic            stall_sent,
    input  logic [EP_W-1:0] clr,
    output logic [EP_W-1:0] flags
);
    logic            b1_set;
    logic [EP_W-1:0] set_v;
    logic [EP_W-1:0] nxt;

    // Select the bank-1 source according to the endpoint variant
    generate
        if (HAS_BANK1) begin : g_b1
            assign b1_set = rxb1;
        end else begin : g_nob1
            assign b1_set = 1'b0;
        end
    endgenerate

    // Build the next flag state: clear first, then sets, then SETUP override
    always_comb begin
        set_v          = '0;
        set_v[F_TX]    = tx;
        set_v[F_RXB0]  = rxb0;
        set_v[F_RXB1]  = b1_set;
        set_v[F_SETUP] = setup;
        set_v[F_NAKI]  = nakin;
        set_v[F_NAKO]  = nakout;
        set_v[F_STALL] = stall_sent;
        nxt = (flags & ~clr) | set_v;
        if (setup) nxt[F_STALL] = 1'b0;
        if (!HAS_BANK1) nxt[F_RXB1] = 1'b0;
    end

    // Flag register
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= nxt;
    end
endmodule

// File: rtl/usbirq_glb_flags.sv
// Device-wide flags: start-of-frame, suspend, and wake-up. Wake-up is
// raised only by a resume that follows a suspend.
module usbirq_glb_flags
    import usbirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof,
    input  logic            suspend,
    input  logic            resume,
    input  logic [GL_W-1:0] clr,
    output logic [GL_W-1:0] flags
);
    logic            in_susp_q;
    logic [GL_W-1:0] set_v;

    // Map events onto flag positions
    always_comb begin
        set_v         = '0;
        set_v[G_SOF]  = sof;
        set_v[G_SUSP] = suspend;
        set_v[G_WAKE] = resume & in_susp_q;
    end

    // Track whether the bus is in the suspended state
    always_ff @(posedge clk) begin
        if (!rst_n)       in_susp_q <= 1'b0;
        else if (suspend) in_susp_q <= 1'b1;
        else if (resume)  in_susp_q <= 1'b0;
    end

    // Flag register, set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_v;
    end
endmodule

// File: rtl/usbirq_req.sv
// Registers the OR of enabled flags and gates it with the two enables.
module usbirq_req #(
    parameter int N = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    input  logic         gie,
    input  logic         usbie,
    output logic         irq
);
    logic pend_q;

    // Pending bit: one cycle after any enabled flag
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= |(flags & enables);
    end

    assign irq = pend_q & gie & usbie;
endmodule

// File: rtl/usb_irq_flags.sv
// Top: per-endpoint and global interrupt flags, register bus, request.
// Map: ep flags at e, ep enables at NUM_EP+e, global flags at 2*NUM_EP,
// global enables at 2*NUM_EP+1, control at 2*NUM_EP+2.
// Assumes register reads have no side effects.
module usb_irq_flags
    import usbirq_pkg::*;
#(
    parameter  int NUM_EP = 4,
    localparam int ADDR_W = $clog2(2 * NUM_EP + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] ev_tx_done,
    input  logic [NUM_EP-1:0] ev_rx_bank0,
    input  logic [NUM_EP-1:0] ev_rx_bank1,
    input  logic [NUM_EP-1:0] ev_setup,
    input  logic [NUM_EP-1:0] ev_nak_in,
    input  logic [NUM_EP-1:0] ev_nak_out,
    input  logic [NUM_EP-1:0] ev_stall_sent,
    input  logic              ev_sof,
    input  logic              ev_suspend,
    input  logic              ev_resume,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic [1:0]        irq_prio
);
    localparam int A_GFLG = 2 * NUM_EP;
    localparam int A_GEN  = 2 * NUM_EP + 1;
    localparam int A_CTRL = 2 * NUM_EP + 2;
    localparam int ALL_W  = NUM_EP * EP_W + GL_W;

    logic [NUM_EP*EP_W-1:0] ep_flags_flat;
    logic [NUM_EP*EP_W-1:0] ep_en_q;
    logic [GL_W-1:0]        glb_flags;
    logic [GL_W-1:0]        glb_en_q;
    logic [3:0]             ctrl_q;
    logic [GL_W-1:0]        glb_clr;

    // Per-endpoint flag blocks; endpoint 0 has no bank-1 flag
    generate
        for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
            logic [EP_W-1:0] clr;
            assign clr = (reg_wr && reg_addr == ADDR_W'(e)) ? reg_wdata[EP_W-1:0] : '0;
            usbirq_ep_flags #(.HAS_BANK1(e != 0)) u_ep (
                .clk        (clk),
                .rst_n      (rst_n),
                .tx         (ev_tx_done[e]),
                .rxb0       (ev_rx_bank0[e]),
                .rxb1       (ev_rx_bank1[e]),
                .setup      (ev_setup[e]),
                .nakin      (ev_nak_in[e]),
                .nakout     (ev_nak_out[e]),
                .stall_sent (ev_stall_sent[e]),
                .clr        (clr),
                .flags      (ep_flags_flat[e*EP_W +: EP_W])
            );
        end
    endgenerate

    assign glb_clr = (reg_wr && reg_addr == ADDR_W'(A_GFLG)) ? reg_wdata[GL_W-1:0] : '0;

    usbirq_glb_flags u_glb (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (ev_sof),
        .suspend (ev_suspend),
        .resume  (ev_resume),
        .clr     (glb_clr),
        .flags   (glb_flags)
    );

    // Enable and control registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep_en_q  <= '0;
            glb_en_q <= '0;
            ctrl_q   <= '0;
        end else if (reg_wr) begin
            for (int e = 0; e < NUM_EP; e++)
                if (reg_addr == ADDR_W'(NUM_EP + e))
                    ep_en_q[e*EP_W +: EP_W] <= reg_wdata[EP_W-1:0];
            if (reg_addr == ADDR_W'(A_GEN))  glb_en_q <= reg_wdata[GL_W-1:0];
            if (reg_addr == ADDR_W'(A_CTRL)) ctrl_q   <= reg_wdata[3:0];
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        for (int e = 0; e < NUM_EP; e++) begin
            if (reg_addr == ADDR_W'(e))
                reg_rdata[EP_W-1:0] = ep_flags_flat[e*EP_W +: EP_W];
            if (reg_addr == ADDR_W'(NUM_EP + e))
                reg_rdata[EP_W-1:0] = ep_en_q[e*EP_W +: EP_W];
        end
        if (reg_addr == ADDR_W'(A_GFLG)) reg_rdata[GL_W-1:0] = glb_flags;
        if (reg_addr == ADDR_W'(A_GEN))  reg_rdata[GL_W-1:0] = glb_en_q;
        if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata[3:0]      = ctrl_q;
    end

    usbirq_req #(.N(ALL_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   ({glb_flags, ep_flags_flat}),
        .enables ({glb_en_q, ep_en_q}),
        .gie     (ctrl_q[C_GIE]),
        .usbie   (ctrl_q[C_USBIE]),
        .irq     (irq)
    );

    assign irq_prio = {ctrl_q[C_PHI], ctrl_q[C_PLO]};
endmodule

// File: rtl/usbirq_chk.sv
// Property checker for usb_irq_flags, attached by bind below.
module usbirq_chk
    import usbirq_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_EP-1:0]      ev_tx_done,
    input logic [NUM_EP-1:0]      ev_setup,
    input logic [NUM_EP-1:0]      ev_nak_in,
    input logic [NUM_EP-1:0]      ev_stall_sent,
    input logic                   ev_sof,
    input logic [NUM_EP*EP_W-1:0] ep_flags,
    input logic [GL_W-1:0]        glb_flags,
    input logic [3:0]             ctrl,
    input logic                   irq
);
    for (genvar e = 0; e < NUM_EP; e++) begin : g_chk
        AST_TX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            ev_tx_done[e] |=> ep_flags[e*EP_W + F_TX]);                 // R1
        AST_SETUP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            ev_setup[e] |=> ep_flags[e*EP_W + F_SETUP]);                // R3
        AST_NAK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            ev_nak_in[e] |=> ep_flags[e*EP_W + F_NAKI]);                // R4
        AST_SETUP_KILLS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
            ev_setup[e] |=> !ep_flags[e*EP_W + F_STALL]);               // R5
        AST_STALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_stall_sent[e] && !ev_setup[e]) |=> ep_flags[e*EP_W + F_STALL]); // R5
    end

    AST_EP0_NO_BANK1: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_flags[F_RXB1]);                                             // R2
    AST_SOF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sof |=> glb_flags[G_SOF]);                                   // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl[C_GIE] && ctrl[C_USBIE]) |-> !irq);                      // R8
endmodule

bind usb_irq_flags usbirq_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_tx_done    (ev_tx_done),
    .ev_setup      (ev_setup),
    .ev_nak_in     (ev_nak_in),
    .ev_stall_sent (ev_stall_sent),
    .ev_sof        (ev_sof),
    .ep_flags      (ep_flags_flat),
    .glb_flags     (glb_flags),
    .ctrl          (ctrl_q),
    .irq           (irq)
);

// File: tb/test_usb_irq_flags.sv
module test_usb_irq_flags;
    localparam int NEP = 4;
    localparam int AW  = 4;
    localparam logic [3:0] A_GF = 4'd8, A_GE = 4'd9, A_CT = 4'd10;

    logic clk = 0, rst_n = 0;
    logic [NEP-1:0] tx = 0, rb0 = 0, rb1 = 0, stp = 0, nki = 0, nko = 0, stl = 0;
    logic sof = 0, susp = 0, res = 0, wr = 0;
    logic [AW-1:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic irq;
    logic [1:0] prio;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    usb_irq_flags #(.NUM_EP(NEP)) i_usb_irq_flags (
        .clk(clk), .rst_n(rst_n), .ev_tx_done(tx), .ev_rx_bank0(rb0),
        .ev_rx_bank1(rb1), .ev_setup(stp), .ev_nak_in(nki), .ev_nak_out(nko),
        .ev_stall_sent(stl), .ev_sof(sof), .ev_suspend(susp), .ev_resume(res),
        .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .irq(irq), .irq_prio(prio));

    // kind, endpoint, expected flag register value
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        {4'd0, 4'd1, 8'h01}, {4'd1, 4'd2, 8'h02}, {4'd2, 4'd1, 8'h04},
        {4'd2, 4'd0, 8'h00}, {4'd3, 4'd3, 8'h08}, {4'd4, 4'd0, 8'h10},
        {4'd5, 4'd2, 8'h20}, {4'd6, 4'd3, 8'h40}};

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic set_ev(int kind, int ep, logic v);
        case (kind)
            0: tx[ep] = v;   1: rb0[ep] = v;  2: rb1[ep] = v;  3: stp[ep] = v;
            4: nki[ep] = v;  5: nko[ep] = v;  6: stl[ep] = v;
            7: sof = v;      8: susp = v;     default: res = v;
        endcase
    endtask

    task automatic fire(int kind, int ep);
        @(negedge clk); set_ev(kind, ep, 1'b1);
        @(negedge clk); set_ev(kind, ep, 1'b0);
    endtask

    task automatic wreg(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0;
    endtask

    task automatic rreg(logic [AW-1:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        for (int a = 0; a <= 10; a++) begin
            rreg(AW'(a), v); check("R10 reset reg", v, 8'h00);
        end
        check("R10 irq", {7'd0, irq}, 8'h00);
        check("R10 prio", {6'd0, prio}, 8'h00);

        // Table walk: R1 R2 R3 R4 R5 set, then R7 clear
        for (int i = 0; i < NV; i++) begin
            fire(int'(VEC[i][15:12]), int'(VEC[i][11:8]));
            rreg(AW'(VEC[i][11:8]), v); check("R1/R2/R3/R4/R5 table set", v, VEC[i][7:0]);
            wreg(AW'(VEC[i][11:8]), 8'h7F);
            rreg(AW'(VEC[i][11:8]), v); check("R7 table clear", v, 8'h00);
        end

        // R4: writing 0 keeps NAK flag; writing 1 clears
        fire(4, 1); fire(5, 1);
        wreg(4'd1, 8'h00); rreg(4'd1, v); check("R4 zero write", v, 8'h30);
        wreg(4'd1, 8'h10); rreg(4'd1, v); check("R4 w1c nakin", v, 8'h20);
        wreg(4'd1, 8'h20);

        // R7: set beats clear in the same cycle, other bit still clears
        fire(5, 2);
        @(negedge clk); tx[2] = 1; wr = 1; addr = 4'd2; wdata = 8'h21;
        @(negedge clk); tx[2] = 0; wr = 0;
        rreg(4'd2, v); check("R7 set wins", v, 8'h01);
        wreg(4'd2, 8'h01);

        // R5: stall then setup clears stall; simultaneous case
        fire(6, 1); rreg(4'd1, v); check("R5 stall set", v, 8'h40);
        fire(3, 1); rreg(4'd1, v); check("R5 setup clears stall", v, 8'h08);
        wreg(4'd1, 8'h7F);
        @(negedge clk); stl[1] = 1; stp[1] = 1;
        @(negedge clk); stl[1] = 0; stp[1] = 0;
        rreg(4'd1, v); check("R5 same-cycle", v, 8'h08);
        wreg(4'd1, 8'h7F);

        // R2: bank-1 on endpoint 0 ignored, works on endpoint 3
        fire(2, 0); rreg(4'd0, v); check("R2 ep0 bank1", v, 8'h00);
        fire(2, 3); rreg(4'd3, v); check("R2 ep3 bank1", v, 8'h04);
        wreg(4'd3, 8'h7F);

        // R6: global flags and wake qualification
        fire(7, 0); rreg(A_GF, v); check("R6 sof", v, 8'h01);
        fire(9, 0); rreg(A_GF, v); check("R6 resume without suspend", v, 8'h01);
        fire(8, 0); rreg(A_GF, v); check("R6 suspend", v, 8'h03);
        fire(9, 0); rreg(A_GF, v); check("R6 wake", v, 8'h07);
        wreg(A_GF, 8'h07); rreg(A_GF, v); check("R6 clear", v, 8'h00);

        // R8: latency, gating and masking
        wreg(4'd7, 8'h01); wreg(A_CT, 8'h03);
        fire(0, 3);
        check("R8 not yet", {7'd0, irq}, 8'h00);
        @(negedge clk); check("R8 one cycle later", {7'd0, irq}, 8'h01);
        wreg(A_CT, 8'h01); check("R8 usb gate", {7'd0, irq}, 8'h00);
        wreg(A_CT, 8'h02); check("R8 global gate", {7'd0, irq}, 8'h00);
        wreg(A_CT, 8'h03); check("R8 both gates", {7'd0, irq}, 8'h01);
        wreg(4'd3, 8'h01); @(negedge clk);
        check("R8 cleared", {7'd0, irq}, 8'h00);
        fire(1, 3); @(negedge clk); @(negedge clk);
        check("R8 masked flag", {7'd0, irq}, 8'h00);
        wreg(4'd3, 8'h7F);
        wreg(A_GE, 8'h01); fire(7, 0); @(negedge clk);
        check("R8 global enable", {7'd0, irq}, 8'h01);
        wreg(A_GF, 8'h07);

        // R9: priority levels
        for (int p = 0; p < 4; p++) begin
            wreg(A_CT, 8'(8'h03 | (p << 2)));
            check("R9 prio", {6'd0, prio}, 8'(p));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1..all got=hang exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule